// File: doc/BRIEF.md
# Dual-Rail Row Parity Corrector

This block sits on the read path of a memory row in which every data bit is kept as a pair of storage nodes: a true node that holds the bit and a complement node that holds its inverse. One more pair of the same kind holds the row's even parity. On a read, the block takes the raw level of every node. It marks any pair whose two nodes agree as faulty. A single faulty data bit is rebuilt from the parity pair and the bits that remain good. The block reports an error flag and an uncorrectable flag, and it reports a both-nodes-low pair on a separate flag.

A particle strike can only pull a node upward, so a struck pair reads as both nodes high. A pair that reads both nodes low points to some other fault, and the block never tries to repair it. The faulty bit is located from its own pair, not from a syndrome, so one parity column is enough to repair one bit per row.

On the write side, the block forms the parity pair that goes with new row data. On the read side, it also offers a fresh parity pair for write-back when only the parity pair was struck. The decode is combinational. A parameter adds an output register that loads on a read-valid strobe.

Top module: `dr_parity_corrector`

## Requirements
- R1: A pair is valid when its nodes differ, with the true node carrying the bit and the complement node its inverse. A bit's value is its true node. When every pair is valid, data_o equals the true nodes and err_o, uncorr_o, dead_o and scrub_o are 0.
- R2: A pair whose nodes are both 1 is upset, and any upset pair sets err_o.
- R3: With exactly one upset data pair and a valid parity pair, the flagged bit is replaced by the parity true node XOR the other data bits (even parity), other bits pass unchanged, and uncorr_o is 0.
- R4: With two or more upset pairs (the parity pair counting as one), uncorr_o and err_o are 1 and data_o equals the raw true nodes.
- R5: With only the parity pair upset, data_o equals the true nodes, err_o and scrub_o are 1, and uncorr_o is 0.
- R6: Any pair with both nodes 0 (data or parity) sets dead_o, uncorr_o and err_o, and data_o equals the raw true nodes.
- R7: wr_par_true_o is the XOR of all bits of wr_data_i, and wr_par_comp_o is its inverse.
- R8: With the output register enabled, the read outputs take the decode of the inputs at the clock edge where rd_valid_i is 1. rd_valid_o is rd_valid_i delayed one cycle. The read outputs hold while rd_valid_i is 0.
- R9: During reset, rd_valid_o, data_o, err_o, uncorr_o, dead_o and scrub_o are 0, and the write-back pair reads (0,1).
- R10: scrub_par_true_o is the XOR of data_o and scrub_par_comp_o is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_valid_i | input | 1 | Read strobe; the raw node values are valid |
| rd_true_i | input | DATA_W | Raw true nodes of the data pairs |
| rd_comp_i | input | DATA_W | Raw complement nodes of the data pairs |
| rd_par_true_i | input | 1 | Raw true node of the parity pair |
| rd_par_comp_i | input | 1 | Raw complement node of the parity pair |
| wr_data_i | input | DATA_W | Row data about to be written |
| wr_par_true_o | output | 1 | Parity true node to write |
| wr_par_comp_o | output | 1 | Parity complement node to write |
| rd_valid_o | output | 1 | Read result valid |
| data_o | output | DATA_W | Corrected row data |
| err_o | output | 1 | At least one faulty pair seen |
| uncorr_o | output | 1 | Row could not be repaired |
| dead_o | output | 1 | A both-nodes-low pair was seen |
| scrub_o | output | 1 | Only the parity pair was struck; rewrite it |
| scrub_par_true_o | output | 1 | Fresh parity true node for write-back |
| scrub_par_comp_o | output | 1 | Fresh parity complement node for write-back |

## Verification
The first reads use clean random rows, so they show whether the true nodes pass through without raising any flag. A single strike is then placed on every data bit position, once with the original bit at 0 and once with it at 1. This separates real parity-based repair from simply copying the forced-high true node. Parity-only strikes show whether the data is left alone and a write-back is requested. Double strikes, data-plus-parity strikes and both-low pairs at data and parity positions show whether repair is suppressed and the raw data is passed through. Idle cycles between reads check that the registered outputs hold.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    PAIR_DEAD  = 2'b00,
    PAIR_ZERO  = 2'b01,
    PAIR_ONE   = 2'b10,
    PAIR_UPSET = 2'b11
  } pair_e;

  typedef struct packed {
    logic err;
    logic uncorr;
    logic dead;
    logic scrub;
  } row_flags_t;
endpackage

// File: rtl/dr_pair_decode.sv
module dr_pair_decode #(
  parameter int N = 16
) (
  input  logic [N-1:0] true_i,
  input  logic [N-1:0] comp_i,
  output logic [N-1:0] upset_o,
  output logic [N-1:0] dead_o
);
  import dr_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pair
    pair_e st;
    assign st         = pair_e'({true_i[i], comp_i[i]});
    assign upset_o[i] = (st == PAIR_UPSET);
    assign dead_o[i]  = (st == PAIR_DEAD);
  end
endmodule

// File: rtl/dr_row_fix.sv
module dr_row_fix #(
  parameter int N = 16
) (
  input  logic [N-1:0]       true_i,
  input  logic [N-1:0]       upset_i,
  input  logic [N-1:0]       dead_i,
  input  logic               par_true_i,
  input  logic               par_upset_i,
  input  logic               par_dead_i,
  output logic [N-1:0]       data_o,
  output dr_pkg::row_flags_t flags_o
);
  localparam int CNT_W = $clog2(N + 2);

  logic [CNT_W-1:0] n_upset;
  logic             any_dead;
  logic             multi;
  logic             fix_bit;
  logic             fix_en;

  always_comb begin
    n_upset = CNT_W'(par_upset_i);
    for (int i = 0; i < N; i++) n_upset = n_upset + CNT_W'(upset_i[i]);
  end

  assign any_dead = (|dead_i) | par_dead_i;
  assign multi    = (n_upset > CNT_W'(1));
  // only the struck bit is masked out; its true node is forced high
  assign fix_bit  = par_true_i ^ (^(true_i & ~upset_i));
  assign fix_en   = !any_dead && !multi && !par_upset_i && (|upset_i);

  assign data_o = fix_en ? ((true_i & ~upset_i) | (upset_i & {N{fix_bit}})) : true_i;

  assign flags_o.err    = any_dead || (n_upset != '0);
  assign flags_o.uncorr = any_dead || multi;
  assign flags_o.dead   = any_dead;
  assign flags_o.scrub  = !any_dead && !multi && par_upset_i;
endmodule

// File: rtl/dr_out_stage.sv
module dr_out_stage #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [N-1:0]       data_i,
  input  dr_pkg::row_flags_t flags_i,
  output logic               valid_o,
  output logic [N-1:0]       data_o,
  output dr_pkg::row_flags_t flags_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
        flags_o <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          data_o  <= data_i;
          flags_o <= flags_i;
        end
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = data_i;
    assign flags_o = flags_i;
  end
endmodule

// File: rtl/dr_parity_corrector.sv
module dr_parity_corrector #(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_true_i,
  input  logic [DATA_W-1:0] rd_comp_i,
  input  logic              rd_par_true_i,
  input  logic              rd_par_comp_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_par_true_o,
  output logic              wr_par_comp_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              uncorr_o,
  output logic              dead_o,
  output logic              scrub_o,
  output logic              scrub_par_true_o,
  output logic              scrub_par_comp_o
);
  import dr_pkg::*;

  logic [DATA_W-1:0] upset, dead, fixed;
  logic [0:0]        par_upset, par_dead;
  row_flags_t        flags_d, flags_q;

  dr_pair_decode #(.N(DATA_W)) u_data_dec (
    .true_i (rd_true_i),
    .comp_i (rd_comp_i),
    .upset_o(upset),
    .dead_o (dead)
  );

  dr_pair_decode #(.N(1)) u_par_dec (
    .true_i (rd_par_true_i),
    .comp_i (rd_par_comp_i),
    .upset_o(par_upset),
    .dead_o (par_dead)
  );

  dr_row_fix #(.N(DATA_W)) u_fix (
    .true_i     (rd_true_i),
    .upset_i    (upset),
    .dead_i     (dead),
    .par_true_i (rd_par_true_i),
    .par_upset_i(par_upset[0]),
    .par_dead_i (par_dead[0]),
    .data_o     (fixed),
    .flags_o    (flags_d)
  );

  dr_out_stage #(.N(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rd_valid_i),
    .data_i (fixed),
    .flags_i(flags_d),
    .valid_o(rd_valid_o),
    .data_o (data_o),
    .flags_o(flags_q)
  );

  assign err_o    = flags_q.err;
  assign uncorr_o = flags_q.uncorr;
  assign dead_o   = flags_q.dead;
  assign scrub_o  = flags_q.scrub;

  assign scrub_par_true_o = ^data_o;
  assign scrub_par_comp_o = ~scrub_par_true_o;

  assign wr_par_true_o = ^wr_data_i;
  assign wr_par_comp_o = ~wr_par_true_o;
endmodule

// File: rtl/dr_parity_checker.sv
module dr_parity_checker #(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic [DATA_W-1:0] rd_true_i,
  input logic [DATA_W-1:0] rd_comp_i,
  input logic              rd_par_true_i,
  input logic              rd_par_comp_i,
  input logic              wr_par_true_o,
  input logic              wr_par_comp_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              err_o,
  input logic              uncorr_o,
  input logic              dead_o,
  input logic              scrub_o
);
  assert_wr_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_par_true_o != wr_par_comp_o);

  assert_uncorr_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> err_o);

  assert_dead_uncorr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> (uncorr_o && err_o));

  assert_scrub_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_o |-> (err_o && !uncorr_o));

  if (REG_OUT) begin : g_seq
    assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_i |=> rd_valid_o);

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_valid_i |=> (!rd_valid_o && $stable(data_o) && $stable(err_o)));

    assert_clean_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && ((rd_true_i ^ rd_comp_i) == {DATA_W{1'b1}}) && (rd_par_true_i ^ rd_par_comp_i))
      |=> (!err_o && data_o == $past(rd_true_i)));

    assert_multi_raw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && ($countones(rd_true_i & rd_comp_i) + int'(rd_par_true_i & rd_par_comp_i)) >= 2)
      |=> (uncorr_o && data_o == $past(rd_true_i)));
  end
endmodule

bind dr_parity_corrector dr_parity_checker #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_valid_i   (rd_valid_i),
  .rd_true_i    (rd_true_i),
  .rd_comp_i    (rd_comp_i),
  .rd_par_true_i(rd_par_true_i),
  .rd_par_comp_i(rd_par_comp_i),
  .wr_par_true_o(wr_par_true_o),
  .wr_par_comp_o(wr_par_comp_o),
  .rd_valid_o   (rd_valid_o),
  .data_o       (data_o),
  .err_o        (err_o),
  .uncorr_o     (uncorr_o),
  .dead_o       (dead_o),
  .scrub_o      (scrub_o)
);

// File: tb/dr_parity_corrector_test.sv
`timescale 1ns/1ps
module dr_parity_corrector_test;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rd_valid_i = 1'b0;
  logic [N-1:0] rd_true_i = '0, rd_comp_i = '0, wr_data_i = '0;
  logic         rd_par_true_i = 1'b0, rd_par_comp_i = 1'b0;
  logic         wr_par_true_o, wr_par_comp_o, rd_valid_o;
  logic [N-1:0] data_o;
  logic         err_o, uncorr_o, dead_o, scrub_o, scrub_par_true_o, scrub_par_comp_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // expected registered state
  logic [N-1:0] e_data = '0;
  logic         e_valid = 0, e_err = 0, e_unc = 0, e_dead = 0, e_scrub = 0;
  string        e_tag = "R9";

  always #2.5 clk = ~clk;

  dr_parity_corrector #(.DATA_W(N), .REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_valid_i(rd_valid_i),
    .rd_true_i(rd_true_i), .rd_comp_i(rd_comp_i),
    .rd_par_true_i(rd_par_true_i), .rd_par_comp_i(rd_par_comp_i),
    .wr_data_i(wr_data_i), .wr_par_true_o(wr_par_true_o), .wr_par_comp_o(wr_par_comp_o),
    .rd_valid_o(rd_valid_o), .data_o(data_o), .err_o(err_o), .uncorr_o(uncorr_o),
    .dead_o(dead_o), .scrub_o(scrub_o),
    .scrub_par_true_o(scrub_par_true_o), .scrub_par_comp_o(scrub_par_comp_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int xor_bits(input logic [N-1:0] v);
    int p = 0;
    for (int i = 0; i < N; i++) if (v[i]) p = p ^ 1;
    return p;
  endfunction

  task automatic compare_outputs();
    logic [6:0] act_f, exp_f;
    int sp;
    check(data_o === e_data, {e_tag, " data"}, 32'(data_o), 32'(e_data));
    act_f = {rd_valid_o, err_o, uncorr_o, dead_o, scrub_o, 2'b00};
    exp_f = {e_valid, e_err, e_unc, e_dead, e_scrub, 2'b00};
    check(act_f === exp_f, {e_tag, " flags(valid,err,unc,dead,scrub)"}, 32'(act_f), 32'(exp_f));
    sp = xor_bits(e_data);
    check({scrub_par_true_o, scrub_par_comp_o} === {sp[0], ~sp[0]}, "R10 scrub pair",
          32'({scrub_par_true_o, scrub_par_comp_o}), 32'({sp[0], ~sp[0]}));
  endtask

  // one clock: check last result, drive a new read (or idle)
  task automatic step(input logic v, input logic [N-1:0] t, input logic [N-1:0] c,
                      input logic pt, input logic pc, input string tag);
    logic [N-1:0] wd;
    int n_up, n_dead, idx, s;
    @(negedge clk);
    compare_outputs();
    wd = N'($urandom);
    rd_valid_i = v; rd_true_i = t; rd_comp_i = c;
    rd_par_true_i = pt; rd_par_comp_i = pc; wr_data_i = wd;
    e_valid = v;
    if (v) begin
      n_up = 0; n_dead = 0; idx = -1;
      for (int i = 0; i < N; i++) begin
        if (t[i] && c[i]) begin n_up++; idx = i; end
        if (!t[i] && !c[i]) n_dead++;
      end
      if (pt && pc) n_up++;
      if (!pt && !pc) n_dead++;
      e_err = (n_up + n_dead) > 0;
      e_unc = (n_dead > 0) || (n_up >= 2);
      e_dead = n_dead > 0;
      e_scrub = !e_unc && n_up == 1 && pt && pc;
      e_data = t;
      if (!e_unc && idx >= 0) begin
        s = pt ? 1 : 0;
        for (int j = 0; j < N; j++) if (j != idx && t[j]) s = s ^ 1;
        e_data[idx] = s[0];
      end
      e_tag = tag;
    end else begin
      e_tag = "R8 hold";
    end
    #1;
    s = xor_bits(wd);
    check({wr_par_true_o, wr_par_comp_o} === {s[0], ~s[0]}, "R7 write pair",
          32'({wr_par_true_o, wr_par_comp_o}), 32'({s[0], ~s[0]}));
  endtask

  function automatic logic par_of(input logic [N-1:0] d);
    int p = xor_bits(d);
    return p[0];
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d, t, c;
    logic p;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({rd_valid_o, err_o, uncorr_o, dead_o, scrub_o} === 5'b0, "R9 reset flags",
          32'({rd_valid_o, err_o, uncorr_o, dead_o, scrub_o}), 32'(0));
    check(data_o === '0, "R9 reset data", 32'(data_o), 32'(0));
    check({scrub_par_true_o, scrub_par_comp_o} === 2'b01, "R9 reset pair",
          32'({scrub_par_true_o, scrub_par_comp_o}), 32'(1));
    rst_ni = 1'b1;

    // R1 clean rows
    for (int k = 0; k < 20; k++) begin
      d = N'($urandom); p = par_of(d);
      step(1, d, ~d, p, ~p, "R1 clean");
    end
    step(0, '0, '0, 0, 0, "R8");
    step(0, '1, '1, 1, 1, "R8");
    // R2/R3 single data upset at every position, original bit 0 and 1
    for (int i = 0; i < N; i++) begin
      for (int b = 0; b < 2; b++) begin
        d = N'($urandom); d[i] = b[0]; p = par_of(d);
        t = d; c = ~d; t[i] = 1'b1; c[i] = 1'b1;
        step(1, t, c, p, ~p, "R3 single fix");
      end
      step(0, '0, '1, 0, 0, "R8");
    end
    // R5 parity-only upset
    for (int k = 0; k < 6; k++) begin
      d = N'($urandom);
      step(1, d, ~d, 1, 1, "R5 parity upset");
    end
    // R4 two data upsets, and data + parity upset
    for (int k = 0; k < 8; k++) begin
      int a = k % N, b2 = (k * 5 + 3) % N;
      d = N'($urandom); p = par_of(d);
      t = d; c = ~d; t[a] = 1; c[a] = 1; t[b2] = 1; c[b2] = 1;
      if (a == b2) step(1, t, c, 1, 1, "R4 data+parity");
      else step(1, t, c, p, ~p, "R4 double");
      t = d; c = ~d; t[b2] = 1; c[b2] = 1;
      step(1, t, c, 1, 1, "R4 data+parity");
    end
    // R6 both-low pairs
    for (int k = 0; k < 6; k++) begin
      d = N'($urandom); p = par_of(d);
      t = d; c = ~d; t[k] = 0; c[k] = 0;
      step(1, t, c, p, ~p, "R6 dead data");
      step(1, d, ~d, 0, 0, "R6 dead parity");
      t = d; c = ~d; t[k+3] = 1; c[k+3] = 1;
      step(1, t, c, 0, 0, "R6 dead parity+upset");
    end
    // R2 upset sets err even when repaired
    d = '0; t = d; c = ~d; t[N-1] = 1; c[N-1] = 1;
    step(1, t, c, 0, 1, "R2 upset err");
    step(0, '0, '0, 0, 0, "R8");
    step(0, '0, '0, 0, 0, "R8");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule